// File: doc/BRIEF.md
# Monochrome Raster-Op Blit Datapath

This block is the per-word datapath of a block-transfer engine for 1-bit-per-pixel image memory. Each image word is 16 bits wide and holds 16 pixels of one plane. A host register port sets the operating mode and the shift amount, the source selection, a 4-bit boolean function and two write-protect masks. Each source word is aligned to the destination bit offset by a funnel shifter. The shifter works on the current word and the word before it. The aligned source is then combined with the destination word and merged under a per-bit mask. The merged word leaves the block one cycle later with a valid strobe.

An address sequencer outside the block supplies the words in row order. It pulses `row_start_i` at the start of each row. It marks the first and last words of a row so the correct edge mask is applied. When the destination bit offset is smaller than the source bit offset, the sequencer flags one extra source word with `prime_i`. That word only fills the shifter and produces no output.

Top module: `mono_blit_dp`

## Requirements
- R1: After reset the output strobe is low, the mode is normal (3'b111) with shift 0, the source is plane data (2'b11) with the boolean function disabled, the function code is 4'h3 and both masks are zero. An interior word therefore passes through unchanged.
- R2: A source word without `prime_i` gives `out_valid_o` high exactly one cycle later. A primed word, or a cycle with no source word, gives `out_valid_o` low in the next cycle.
- R3: In block-transfer mode (control bits [7:5] = 3'b100), the aligned source bit i is bit (i+k) of the 32-bit value {previous word, current word}. Here k is control bits [3:0], which is the 5-bit shift field [4:0] taken modulo 16.
- R4: `row_start_i` clears the previous-word register. A word presented in the same cycle already sees zero as its previous word.
- R5: In any mode other than block transfer, including vector (3'b010) and normal (3'b111), the source is not shifted, whatever the shift field holds.
- R6: Source select bits [7:6] of register 1: 2'b00 forces all ones, 2'b01 replicates bit 0 of the incoming word across all 16 bits, and 2'b10 or 2'b11 uses the aligned plane data.
- R7: When the enable bit (register 1 bit 4) is set, result bit i equals bit {~S[i],~D[i]} of the 4-bit code in register 2. For example 4'h1 gives AND, 4'h6 gives XOR and 4'hE gives NAND.
- R8: When the enable bit is clear, the result equals the selected source, whatever the function code.
- R9: Mask bit 1 keeps the destination bit and mask bit 0 stores the result. A first-only word uses the head mask (register 3), a last-only word uses the tail mask (register 4), a word that is both first and last uses their OR, and an interior word is unmasked.
- R10: Register writes select by `cfg_addr_i`: 0 control, 1 source select, 2 function, 3 head mask, 4 tail mask. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 16 | Register write data |
| row_start_i | input | 1 | Clears the previous-word register |
| src_valid_i | input | 1 | Source word present |
| prime_i | input | 1 | Word only fills the shifter, no output |
| first_i | input | 1 | First word of a row |
| last_i | input | 1 | Last word of a row |
| src_i | input | 16 | Source word |
| dst_i | input | 16 | Destination word read from memory |
| out_valid_o | output | 1 | Merged word valid |
| out_o | output | 16 | Merged word |

## Verification
A stale or uncleared previous-word register corrupts the high bits of the first output word of a row. It shows only for non-zero shifts in block-transfer mode, one cycle after that word. For this reason the shift sweep starts every row with `row_start_i` and checks both words at each of the 16 shift values. A wrong function or mask register shows in the very next output word. The bench covers every function code against the four S/D bit combinations, and all four first/last mask cases, so a single flipped bit in a register shows up immediately.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int DW = 16;
  localparam int SW = $clog2(DW);
  localparam int AW = 3;

  localparam logic [2:0] MODE_VEC  = 3'b010;
  localparam logic [2:0] MODE_BLT  = 3'b100;
  localparam logic [2:0] MODE_NORM = 3'b111;

  localparam logic [1:0] SRC_ONES  = 2'b00;
  localparam logic [1:0] SRC_PIX   = 2'b01;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_SRC  = 3'd1;
  localparam logic [AW-1:0] A_FN   = 3'd2;
  localparam logic [AW-1:0] A_HEAD = 3'd3;
  localparam logic [AW-1:0] A_TAIL = 3'd4;
endpackage

// File: rtl/mbd_cfg_regs.sv
module mbd_cfg_regs
  import mbd_pkg::*;
#(
  parameter int W  = DW,
  parameter int SH = SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [2:0]    mode_o,
  output logic [SH-1:0] shift_o,
  output logic [1:0]    src_sel_o,
  output logic          fn_en_o,
  output logic [3:0]    fn_o,
  output logic [W-1:0]  head_mask_o,
  output logic [W-1:0]  tail_mask_o
);
  logic [7:0] ctrl_q;
  logic [7:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= {MODE_NORM, 5'd0};
      src_q       <= 8'hC0;
      fn_o        <= 4'h3;
      head_mask_o <= '0;
      tail_mask_o <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_CTRL:  ctrl_q      <= wdata_i[7:0];
        A_SRC:   src_q       <= wdata_i[7:0];
        A_FN:    fn_o        <= wdata_i[3:0];
        A_HEAD:  head_mask_o <= wdata_i;
        A_TAIL:  tail_mask_o <= wdata_i;
        default: ;
      endcase
    end
  end

  assign mode_o    = ctrl_q[7:5];
  assign shift_o   = ctrl_q[SH-1:0];  // modulo word width
  assign src_sel_o = src_q[7:6];
  assign fn_en_o   = src_q[4];
endmodule

// File: rtl/mbd_funnel.sv
module mbd_funnel
  import mbd_pkg::*;
#(
  parameter int W  = DW,
  parameter int SH = SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          row_start_i,
  input  logic          bypass_i,
  input  logic [SH-1:0] shift_i,
  input  logic [W-1:0]  src_i,
  output logic [W-1:0]  aligned_o
);
  logic [W-1:0]   prev_q;
  logic [W-1:0]   prev_eff;
  logic [2*W-1:0] cat_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          prev_q <= '0;
    else if (valid_i)     prev_q <= src_i;
    else if (row_start_i) prev_q <= '0;
  end

  assign prev_eff  = row_start_i ? '0 : prev_q;
  assign cat_sh    = {prev_eff, src_i} >> shift_i;
  assign aligned_o = bypass_i ? src_i : cat_sh[W-1:0];
endmodule

// File: rtl/mbd_rop.sv
module mbd_rop #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [3:0]   fn_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] r_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign r_o[i] = en_i ? fn_i[{~s_i[i], ~d_i[i]}] : s_i[i];
  end
endmodule

// File: rtl/mono_blit_dp.sv
module mono_blit_dp
  import mbd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [15:0]   cfg_wdata_i,
  input  logic          row_start_i,
  input  logic          src_valid_i,
  input  logic          prime_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic [15:0]   src_i,
  input  logic [15:0]   dst_i,
  output logic          out_valid_o,
  output logic [15:0]   out_o
);
  logic [2:0]    mode;
  logic [SW-1:0] shift;
  logic [1:0]    src_sel;
  logic          fn_en;
  logic [3:0]    fn;
  logic [DW-1:0] head_mask, tail_mask;
  logic [DW-1:0] aligned, s_word, r_word, mask, merged;

  mbd_cfg_regs #(.W(DW), .SH(SW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .mode_o(mode), .shift_o(shift), .src_sel_o(src_sel),
    .fn_en_o(fn_en), .fn_o(fn),
    .head_mask_o(head_mask), .tail_mask_o(tail_mask)
  );

  mbd_funnel #(.W(DW), .SH(SW)) u_funnel (
    .clk_i, .rst_ni,
    .valid_i(src_valid_i), .row_start_i,
    .bypass_i(mode != MODE_BLT), .shift_i(shift),
    .src_i, .aligned_o(aligned)
  );

  always_comb begin
    unique case (src_sel)
      SRC_ONES: s_word = '1;
      SRC_PIX:  s_word = {DW{src_i[0]}};
      default:  s_word = aligned;
    endcase
  end

  mbd_rop #(.W(DW)) u_rop (
    .en_i(fn_en), .fn_i(fn), .s_i(s_word), .d_i(dst_i), .r_o(r_word)
  );

  always_comb begin
    unique case ({first_i, last_i})
      2'b10:   mask = head_mask;
      2'b01:   mask = tail_mask;
      2'b11:   mask = head_mask | tail_mask;
      default: mask = '0;
    endcase
  end

  assign merged = (mask & dst_i) | (~mask & r_word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_o       <= '0;
    end else begin
      out_valid_o <= src_valid_i & ~prime_i;
      if (src_valid_i && !prime_i) out_o <= merged;
    end
  end
endmodule

// File: rtl/mbd_chk.sv
module mbd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        src_valid_i,
  input logic        prime_i,
  input logic        first_i,
  input logic        last_i,
  input logic [15:0] src_i,
  input logic [15:0] dst_i,
  input logic        out_valid_o,
  input logic [15:0] out_o,
  input logic [2:0]  mode,
  input logic [1:0]  src_sel,
  input logic        fn_en,
  input logic [15:0] head_mask
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i && !prime_i |=> out_valid_o);

  a_r2_prime_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_valid_i && !prime_i) |=> !out_valid_o);

  a_r9_full_mask_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i && !prime_i && first_i && !last_i && head_mask == 16'hFFFF
    |=> out_o == $past(dst_i));

  a_r8_fn_off_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i && !prime_i && !first_i && !last_i && !fn_en &&
    src_sel == 2'b11 && mode != 3'b100 |=> out_o == $past(src_i));

  a_r6_vector_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i && !prime_i && !first_i && !last_i && !fn_en &&
    src_sel == 2'b00 |=> out_o == 16'hFFFF);
endmodule

bind mono_blit_dp mbd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_valid_i(src_valid_i),
  .prime_i(prime_i), .first_i(first_i), .last_i(last_i),
  .src_i(src_i), .dst_i(dst_i), .out_valid_o(out_valid_o), .out_o(out_o),
  .mode(mode), .src_sel(src_sel), .fn_en(fn_en), .head_mask(head_mask)
);

// File: tb/mono_blit_dp_tb.sv
module mono_blit_dp_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        row_start_i = 1'b0, src_valid_i = 1'b0, prime_i = 1'b0;
  logic        first_i = 1'b0, last_i = 1'b0;
  logic [15:0] src_i = '0, dst_i = '0;
  logic        out_valid_o;
  logic [15:0] out_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model of configuration
  logic [2:0]  m_mode = 3'b111;
  logic [3:0]  m_sh = '0;
  logic [1:0]  m_sel = 2'b11;
  logic        m_en = 1'b0;
  logic [3:0]  m_fn = 4'h3;
  logic [15:0] m_head = '0, m_tail = '0, m_prev = '0;
  logic [15:0] last_out;

  always #2 clk_i = ~clk_i;

  mono_blit_dp u_dut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (a)
      3'd0: begin m_mode = d[7:5]; m_sh = d[3:0]; end
      3'd1: begin m_sel = d[7:6]; m_en = d[4]; end
      3'd2: m_fn = d[3:0];
      3'd3: m_head = d;
      3'd4: m_tail = d;
      default: ;
    endcase
  endtask

  function automatic logic [15:0] model(logic [15:0] prev, logic [15:0] cur,
                                        logic [15:0] d, logic f, logic l);
    logic [15:0] al, s, r, mk;
    for (int i = 0; i < 16; i++) begin
      if (m_mode != 3'b100) al[i] = cur[i];
      else if (i + m_sh < 16) al[i] = cur[i + m_sh];
      else al[i] = prev[i + m_sh - 16];
    end
    if (m_sel == 2'b00) s = 16'hFFFF;
    else if (m_sel == 2'b01) s = cur[0] ? 16'hFFFF : 16'h0000;
    else s = al;
    for (int i = 0; i < 16; i++)
      r[i] = m_en ? m_fn[(s[i] ? 0 : 2) + (d[i] ? 0 : 1)] : s[i];
    mk = (f && l) ? (m_head | m_tail) : f ? m_head : l ? m_tail : 16'h0;
    return (mk & d) | (~mk & r);
  endfunction

  task automatic push(string req, logic [15:0] s, logic [15:0] d,
                      logic f, logic l, logic pr, logic rs);
    logic [15:0] exp;
    @(negedge clk_i);
    src_valid_i = 1'b1; src_i = s; dst_i = d;
    first_i = f; last_i = l; prime_i = pr; row_start_i = rs;
    exp = model(rs ? 16'h0 : m_prev, s, d, f, l);
    @(negedge clk_i);
    src_valid_i = 1'b0; prime_i = 1'b0; row_start_i = 1'b0;
    first_i = 1'b0; last_i = 1'b0;
    m_prev = s;
    last_out = out_o;
    check({req, " valid"}, {15'd0, out_valid_o}, {15'd0, ~pr});
    if (!pr) check(req, out_o, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 strobe low", {15'd0, out_valid_o}, 16'h0);
    push("R1 default pass", 16'h1234, 16'hFFFF, 0, 0, 0, 0);
    check("R1 literal", last_out, 16'h1234);
    wr(3'd1, 16'h00D0);
    push("R1 default fn copy", 16'h5A3C, 16'h0F0F, 0, 0, 0, 0);
    check("R1 fn 3 literal", last_out, 16'h5A3C);

    // R7 all function codes, S=F0F0 D=CCCC covers every bit pair
    for (int f = 0; f < 16; f++) begin
      wr(3'd2, 16'(f));
      push("R7 fn sweep", 16'hF0F0, 16'hCCCC, 0, 0, 0, 0);
    end
    wr(3'd2, 16'h1); push("R7 and", 16'hF0F0, 16'hCCCC, 0, 0, 0, 0);
    check("R7 and literal", last_out, 16'hC0C0);
    wr(3'd2, 16'h6); push("R7 xor", 16'hF0F0, 16'hCCCC, 0, 0, 0, 0);
    check("R7 xor literal", last_out, 16'h3C3C);
    wr(3'd2, 16'hE); push("R7 nand", 16'hF0F0, 16'hCCCC, 0, 0, 0, 0);
    check("R7 nand literal", last_out, 16'h3F3F);

    // R8 disabled function copies source
    wr(3'd2, 16'h0); wr(3'd1, 16'h00C0);
    push("R8 disabled", 16'h9182, 16'h7777, 0, 0, 0, 0);
    check("R8 literal", last_out, 16'h9182);

    // R3/R4 shift sweep in block-transfer mode
    for (int k = 0; k < 16; k++) begin
      wr(3'd0, 16'h0080 | 16'(k));
      push("R4 row start word", 16'hA5C3, 16'h0000, 0, 0, 0, 1);
      push("R3 second word", 16'h3E71, 16'h0000, 0, 0, 0, 0);
    end
    wr(3'd0, 16'h0094);  // shift field 20 -> 4
    push("R4 row start", 16'h00F0, 16'h0, 0, 0, 0, 1);
    push("R3 modulo", 16'h1234, 16'h0, 0, 0, 0, 0);
    check("R3 modulo literal", last_out, 16'h0123);

    // R2 priming word
    wr(3'd0, 16'h0088);
    push("R2 prime", 16'hBEEF, 16'h0, 0, 0, 1, 1);
    push("R2 after prime", 16'h1357, 16'h0, 0, 0, 0, 0);
    check("R2 prime literal", last_out, 16'hEF13);
    @(negedge clk_i);
    check("R2 idle low", {15'd0, out_valid_o}, 16'h0);

    // R5 no shift outside block-transfer mode
    wr(3'd0, 16'h00E5);
    push("R5 normal", 16'hC001, 16'h0, 0, 0, 0, 0);
    check("R5 normal literal", last_out, 16'hC001);
    wr(3'd0, 16'h0047);
    push("R5 vector", 16'h8421, 16'h0, 0, 0, 0, 0);
    check("R5 vector literal", last_out, 16'h8421);

    // R6 source select
    wr(3'd1, 16'h0000); push("R6 ones", 16'h0000, 16'h1111, 0, 0, 0, 0);
    wr(3'd1, 16'h0040); push("R6 pix one", 16'h0001, 16'h0, 0, 0, 0, 0);
    check("R6 pix literal", last_out, 16'hFFFF);
    push("R6 pix zero", 16'hFFFE, 16'hFFFF, 0, 0, 0, 0);
    wr(3'd1, 16'h0080); push("R6 alt plane", 16'h6C6C, 16'h0, 0, 0, 0, 0);
    wr(3'd1, 16'h00C0); push("R6 plane", 16'h2468, 16'h0, 0, 0, 0, 0);

    // R9 masks, with XOR to separate keep from store
    wr(3'd0, 16'h00E0); wr(3'd1, 16'h00D0); wr(3'd2, 16'h6);
    wr(3'd3, 16'hFF00); wr(3'd4, 16'h000F);
    for (int c = 0; c < 4; c++)
      push("R9 mask case", 16'hFFFF, 16'hA5A5, c[1], c[0], 0, 0);
    push("R9 both", 16'hFFFF, 16'hA5A5, 1, 1, 0, 0);
    check("R9 both literal", last_out, 16'hA555);

    // R10 unused addresses change nothing
    wr(3'd5, 16'hFFFF); wr(3'd6, 16'h0000); wr(3'd7, 16'h1234);
    m_mode = 3'b111; m_sh = '0; m_sel = 2'b11; m_en = 1'b1; m_fn = 4'h6;
    m_head = 16'hFF00; m_tail = 16'h000F;
    push("R10 unchanged first", 16'h0F0F, 16'h3333, 1, 0, 0, 0);
    push("R10 unchanged mid", 16'h0F0F, 16'h3333, 0, 0, 0, 0);
    check("R10 literal", last_out, 16'h3C3C);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule